// File: doc/BRIEF.md
# Failed Access Attempt Limiter

This block tracks unsuccessful access attempts and decides whether more attempts are allowed. It holds a limit register, an attempt counter and an enable bit. Each of the three can be written through a configuration port, and a write takes effect only while the configuration-mode input is high. Once enabled, every failed-attempt strobe advances the counter by one, wrapping modulo 2^CNT_W. When the counter reaches the limit, the block locks out further attempts.

The number of failures allowed is (limit − preloaded counter) mod 2^CNT_W. A counter preloaded above the limit therefore wraps through its maximum value before lockout, and with 8 bits this gives up to 255 extra attempts. The block reports the counter, the attempts still remaining and the lockout flag.

A three-state machine holds the protection status:
- **GS_OFF**: counting is disabled.
- **GS_ARMED**: counting is enabled and the block is not locked.
- **GS_LOCKED**: lockout.

Its transitions are:
- **OFF→ARMED**: enable is written to 1 and the counter differs from the limit.
- **OFF→LOCKED** and **ARMED→LOCKED**: with enable at 1, the counter equals the limit. This happens after a failed attempt or after a configuration write.
- **ARMED→OFF**: enable is written to 0.
- **LOCKED→OFF**, **LOCKED→ARMED** and **LOCKED→LOCKED**: a counter write is accepted, and the new state is chosen from the new values.
- **Hold**: all other cases leave the state unchanged.

Top module: `attempt_guard`

## Requirements
- R1: After reset, the counter, the limit and the enable bit are 0, `locked_o` is 0 and `remain_o` is 0.
- R2: A write to the limit, the counter or the enable bit takes effect at the next clock edge only when `cfg_mode` is 1. Any value from 0 to 255 is accepted. With `cfg_mode` at 0, writes are ignored.
- R3: While enable is 0, failed-attempt strobes leave the counter unchanged and never assert `locked_o`.
- R4: While enabled and not locked, a failed attempt (`att_stb`=1, `att_pass`=0) increments `cnt_o` by one modulo 256. The new value is visible after the next clock edge.
- R5: `locked_o` goes to 1 on the edge after which the counter equals the limit with enable at 1. The number of failures allowed is (limit − preload) mod 256. For example, limit 3 with preload 250 allows 9 failures, and limit 0 with preload 1 allows 255.
- R6: While locked, the counter does not move and `locked_o` stays 1. Only an accepted counter write or reset releases the lock; a write to the limit or the enable bit does not.
- R7: A successful access (`att_stb`=1, `att_pass`=1) changes neither the counter nor the lock.
- R8: `remain_o` equals (limit − counter) mod 256 while unlocked, and 0 while locked.
- R9: If any accepted configuration write and a failed attempt occur in the same cycle, the write is applied and the attempt is discarded.
- R10: After an accepted counter write, the lock is re-evaluated from the new values. Enable 1 with the counter equal to the limit locks again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mode | input | 1 | Configuration mode; gates all writes |
| lim_we | input | 1 | Limit write strobe |
| lim_wd | input | CNT_W | Limit write data |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wd | input | CNT_W | Counter write data |
| en_we | input | 1 | Enable write strobe |
| en_wd | input | 1 | Enable write data |
| att_stb | input | 1 | Access result strobe |
| att_pass | input | 1 | 1 = access succeeded, 0 = failed |
| cnt_o | output | CNT_W | Current attempt counter |
| remain_o | output | CNT_W | Attempts remaining before lockout |
| locked_o | output | 1 | Lockout flag |

## Verification
The bench builds the block with its default CNT_W of 8, so every counter and limit value from 0 to 255 can be reached. This also brings the full wrap within reach: the limit-0, preload-1 case needs 255 failed strobes. A behavioural model updates on every clock and is compared against all three outputs. Directed checks count the failures needed to reach lockout from several preloads, and cover lock release, writes while not in configuration mode, and a write colliding with a failed attempt.

// File: rtl/attempt_guard_pkg.sv
`timescale 1ns/1ps
package attempt_guard_pkg;
    typedef enum logic [1:0] {
        GS_OFF    = 2'd0,
        GS_ARMED  = 2'd1,
        GS_LOCKED = 2'd2
    } guard_state_t;
endpackage

// File: rtl/guard_regs.sv
`timescale 1ns/1ps
module guard_regs #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic             lim_we,
    input  logic [CNT_W-1:0] lim_wd,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wd,
    input  logic             en_we,
    input  logic             en_wd,
    input  logic             inc,
    output logic [CNT_W-1:0] lim_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             en_q,
    output logic [CNT_W-1:0] lim_n,
    output logic [CNT_W-1:0] cnt_n,
    output logic             en_n,
    output logic             wr_any,
    output logic             cnt_wr
);
    logic lim_wr;
    logic en_wr;

    always_comb begin
        lim_wr = cfg_mode && lim_we;
        cnt_wr = cfg_mode && cnt_we;
        en_wr  = cfg_mode && en_we;
        wr_any = lim_wr || cnt_wr || en_wr;
        lim_n  = lim_wr ? lim_wd : lim_q;
        en_n   = en_wr  ? en_wd  : en_q;
        if (cnt_wr)
            cnt_n = cnt_wd;
        else if (inc)
            cnt_n = cnt_q + CNT_W'(1);
        else
            cnt_n = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lim_q <= '0;
            cnt_q <= '0;
            en_q  <= 1'b0;
        end else begin
            lim_q <= lim_n;
            cnt_q <= cnt_n;
            en_q  <= en_n;
        end
    end

    AST_CFG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_mode |=> ($stable(lim_q) && $stable(en_q))); // R2

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_any |=> ((cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))))); // R4
endmodule

// File: rtl/guard_fsm.sv
`timescale 1ns/1ps
module guard_fsm #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             att_stb,
    input  logic             att_pass,
    input  logic             wr_any,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] lim_n,
    input  logic [CNT_W-1:0] cnt_n,
    input  logic             en_n,
    output logic             inc,
    output logic             locked
);
    import attempt_guard_pkg::*;

    guard_state_t state_q;
    guard_state_t state_d;
    guard_state_t judged;

    always_comb begin
        if (!en_n)
            judged = GS_OFF;
        else if (cnt_n == lim_n)
            judged = GS_LOCKED;
        else
            judged = GS_ARMED;
    end

    always_comb begin
        unique case (state_q)
            GS_OFF:    state_d = judged;
            GS_ARMED:  state_d = judged;
            GS_LOCKED: state_d = cnt_wr ? judged : GS_LOCKED;
            default:   state_d = GS_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= GS_OFF;
        else
            state_q <= state_d;
    end

    always_comb begin
        inc    = 1'b0;
        locked = 1'b0;
        unique case (state_q)
            GS_OFF:    ;
            GS_ARMED:  inc = att_stb && !att_pass && !wr_any;
            GS_LOCKED: locked = 1'b1;
            default:   ;
        endcase
    end

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && !cnt_wr) |=> locked); // R6

    AST_LOCK_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !en_n) |=> !locked); // R3
endmodule

// File: rtl/guard_report.sv
`timescale 1ns/1ps
module guard_report #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] lim_q,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic             locked,
    output logic [CNT_W-1:0] remain
);
    logic [CNT_W-1:0] gap;

    always_comb begin
        gap    = lim_q - cnt_q;
        remain = locked ? '0 : gap;
    end
endmodule

// File: rtl/attempt_guard.sv
`timescale 1ns/1ps
module attempt_guard #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_mode,
    input  logic             lim_we,
    input  logic [CNT_W-1:0] lim_wd,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wd,
    input  logic             en_we,
    input  logic             en_wd,
    input  logic             att_stb,
    input  logic             att_pass,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] remain_o,
    output logic             locked_o
);
    logic [CNT_W-1:0] lim_q, cnt_q, lim_n, cnt_n;
    logic             en_q, en_n, wr_any, cnt_wr, inc, locked;

    guard_regs #(.CNT_W(CNT_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .lim_we(lim_we), .lim_wd(lim_wd), .cnt_we(cnt_we), .cnt_wd(cnt_wd),
        .en_we(en_we), .en_wd(en_wd), .inc(inc),
        .lim_q(lim_q), .cnt_q(cnt_q), .en_q(en_q),
        .lim_n(lim_n), .cnt_n(cnt_n), .en_n(en_n),
        .wr_any(wr_any), .cnt_wr(cnt_wr)
    );

    guard_fsm #(.CNT_W(CNT_W)) fsm_i (
        .clk(clk), .rst_n(rst_n), .att_stb(att_stb), .att_pass(att_pass),
        .wr_any(wr_any), .cnt_wr(cnt_wr), .lim_n(lim_n), .cnt_n(cnt_n),
        .en_n(en_n), .inc(inc), .locked(locked)
    );

    guard_report #(.CNT_W(CNT_W)) report_i (
        .lim_q(lim_q), .cnt_q(cnt_q), .locked(locked), .remain(remain_o)
    );

    assign cnt_o    = cnt_q;
    assign locked_o = locked;

    AST_PASS_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (att_stb && att_pass && !wr_any) |=> ($stable(cnt_q) && $stable(locked_o))); // R7

    AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_o && !cnt_wr) |=> $stable(cnt_q)); // R6

    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !wr_any) |=> $stable(cnt_q)); // R3

    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !cnt_wr) |=> $stable(cnt_q)); // R9
endmodule

// File: tb/attempt_guard_tb_top.sv
`timescale 1ns/1ps
module attempt_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_mode = 0, lim_we = 0, cnt_we = 0, en_we = 0, en_wd = 0;
    logic       att_stb = 0, att_pass = 0;
    logic [7:0] lim_wd = 0, cnt_wd = 0;
    logic [7:0] cnt_o, remain_o;
    logic       locked_o;

    int    errors = 0;
    int    checks = 0;
    bit    done = 0;
    string tag = "R1";

    int m_lim = 0, m_cnt = 0, m_en = 0, m_lock = 0;

    always #10 clk = ~clk;

    attempt_guard #(.CNT_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
        .lim_we(lim_we), .lim_wd(lim_wd), .cnt_we(cnt_we), .cnt_wd(cnt_wd),
        .en_we(en_we), .en_wd(en_wd), .att_stb(att_stb), .att_pass(att_pass),
        .cnt_o(cnt_o), .remain_o(remain_o), .locked_o(locked_o)
    );

    task automatic chk(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic compare();
        chk(tag, cnt_o, m_cnt, "cnt_o");
        chk(tag, locked_o, m_lock, "locked_o");
        chk(tag, remain_o, m_lock ? 0 : ((m_lim - m_cnt) & 255), "remain_o");
    endtask

    task automatic cyc(input bit c, input bit lw, input int ld, input bit cw, input int cd,
                       input bit ew, input bit ed, input bit s, input bit p);
        cfg_mode = c; lim_we = lw; lim_wd = 8'(ld); cnt_we = cw; cnt_wd = 8'(cd);
        en_we = ew; en_wd = ed; att_stb = s; att_pass = p;
        @(posedge clk);
        if (c && (lw || cw || ew)) begin
            if (lw) m_lim = ld & 255;
            if (ew) m_en = ed;
            if (cw) m_cnt = cd & 255;
            if (!(m_lock && !cw)) m_lock = (m_en && m_cnt == m_lim) ? 1 : 0;
        end else if (s && !p && m_en && !m_lock) begin
            m_cnt = (m_cnt + 1) & 255;
            m_lock = (m_cnt == m_lim) ? 1 : 0;
        end
        @(negedge clk);
        compare();
    endtask

    task automatic idle();
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic fail();
        cyc(0, 0, 0, 0, 0, 0, 0, 1, 0);
    endtask

    task automatic setup(input int lim, input int cnt, input bit en);
        cyc(1, 1, lim, 1, cnt, 1, en, 0, 0);
    endtask

    task automatic count_to_lock(input int expect_n, input string req);
        int n = 0;
        while (!locked_o && n < 300) begin
            fail();
            n++;
        end
        chk(req, n, expect_n, "failures until lockout");
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        tag = "R1";
        compare();
        rst_n = 1'b1;
        idle();

        // R2: writes outside configuration mode are ignored
        tag = "R2";
        cyc(0, 1, 9, 1, 4, 1, 1, 0, 0);
        chk("R2", cnt_o, 0, "counter after write without cfg_mode");
        chk("R2", remain_o, 0, "limit after write without cfg_mode");
        setup(5, 2, 1);
        chk("R2", remain_o, 3, "remaining after cfg write");
        // R8 remaining tracks difference
        tag = "R8";
        idle();

        // R4/R5: count up to lock
        tag = "R4";
        fail();
        chk("R4", cnt_o, 3, "counter after one failure");
        tag = "R5";
        count_to_lock(2, "R5");
        chk("R8", remain_o, 0, "remaining while locked");

        // R6: frozen while locked, limit/enable writes do not release
        tag = "R6";
        repeat (4) fail();
        chk("R6", cnt_o, 5, "counter frozen while locked");
        cyc(1, 1, 20, 0, 0, 0, 0, 0, 0);
        cyc(1, 0, 0, 0, 0, 1, 0, 0, 0);
        chk("R6", locked_o, 1, "lock after limit/enable writes");
        cyc(1, 0, 0, 1, 0, 1, 1, 0, 0);
        chk("R6", locked_o, 0, "lock released by counter write");
        chk("R8", remain_o, 20, "remaining after release");

        // R7: successful accesses do nothing
        tag = "R7";
        repeat (5) cyc(0, 0, 0, 0, 0, 0, 0, 1, 1);
        chk("R7", cnt_o, 0, "counter after successful accesses");

        // R3: disabled counting
        tag = "R3";
        setup(2, 1, 0);
        repeat (10) fail();
        chk("R3", cnt_o, 1, "counter while disabled");
        chk("R3", locked_o, 0, "lock while disabled");

        // R5: wrap-around preload
        tag = "R5";
        setup(3, 250, 1);
        count_to_lock(9, "R5");
        chk("R5", cnt_o, 3, "counter after wrap");
        setup(0, 1, 1);
        count_to_lock(255, "R5");

        // R9: write collides with failure
        tag = "R9";
        setup(10, 4, 1);
        cyc(1, 1, 12, 0, 0, 0, 0, 1, 0);
        chk("R9", cnt_o, 4, "failure discarded on write cycle");
        chk("R9", remain_o, 8, "limit write applied");
        cyc(0, 0, 0, 1, 7, 0, 0, 1, 0);
        chk("R9", cnt_o, 5, "counter write without cfg_mode ignored, failure counted");

        // R10: counter write equal to limit re-locks
        tag = "R10";
        cyc(1, 0, 0, 1, 12, 0, 0, 0, 0);
        chk("R10", locked_o, 1, "lock after equal counter write");
        cyc(1, 0, 0, 1, 12, 0, 0, 0, 0);
        chk("R10", locked_o, 1, "relock after rewrite of equal value");
        cyc(1, 0, 0, 1, 11, 0, 0, 0, 0);
        chk("R10", locked_o, 0, "unlock after unequal counter write");
        fail();
        chk("R10", locked_o, 1, "lock after last failure");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule